// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores received frames into a circular region of a local packet memory. The region is cut into 256-byte pages and runs from a start page up to, but not including, a stop page. Every frame takes one or more whole pages. The first four bytes of its first page are kept for a header that describes the frame, and the frame bytes follow at offset 4. Once the last byte has arrived, the header is written and the current-page register moves to the first free page after the frame.

The host reads frames from the ring in order. It advances a boundary register that names the page just before the oldest frame it has not yet read. If a byte would be written into the boundary page, the ring is full. In that case the rest of the frame is discarded, no header is written, the current page keeps its value, and both an overwrite request and a missed-frame pulse are raised.

The controller is a four-state machine:
- ST_IDLE waits for the first byte.
- ST_DATA stores the following bytes.
- ST_HDR spends four cycles writing the header.
- ST_DROP discards the rest of a frame that ran into the boundary.

Transitions:
- ST_IDLE→ST_DATA on an accepted first byte.
- ST_IDLE/ST_DATA→ST_HDR on an accepted final byte.
- ST_HDR→ST_IDLE after the fourth header byte.
- ST_IDLE/ST_DATA→ST_DROP on a boundary hit with more bytes still to come.
- ST_IDLE/ST_DATA→ST_IDLE on a boundary hit on the final byte.
- ST_DROP→ST_IDLE on the final byte.

The source must leave at least four idle cycles after each final byte.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, cur_page equals START_RST, bnd_page equals STOP_RST-1, and no memory write is issued.
- R2: When cfg_we is high, cfg_data is loaded into one register chosen by cfg_sel: 0 = start page, 1 = stop page, 2 = boundary page, 3 = current page. The boundary and current pages are visible on bnd_page and cur_page one cycle later.
- R3: Byte k of a frame (k from 0) is written in the same cycle it is presented. The next byte after offset 255 goes to offset 0 of the next page. Byte k therefore lands at linear offset 4+k, counted from the start of the current page at frame start.
- R4: The page that follows stop-1 is the start page. This applies both to data addresses and to the next-page link.
- R5: After the final byte, the header is written in four consecutive cycles to offsets 0, 1, 2 and 3 of the frame's first page. These bytes hold, in order: the status byte, the next-page link, the low length byte and the high length byte.
- R6: The stored length is the number of bytes presented for the frame. The four CRC bytes at the end of the stream are included.
- R7: Status byte encoding:
  - bit0 is 1 when none of rx_err[2:0] is set at the final byte.
  - bit1 = rx_err[0] (CRC error).
  - bit2 = rx_err[1] (alignment error).
  - bit3 = rx_err[2] (FIFO overrun).
  - bit5 = rx_match.
  - All other bits are 0.
- R8: The next-page link is the page after the one that holds the final byte. cur_page takes this value in the cycle after the fourth header write. irq_rx pulses for one cycle with that header write only when status bit0 is 1.
- R9: Any byte that would be written into the boundary page, whether as a frame's first byte or on a page crossing, is not written. irq_ovw and rx_missed then pulse once, the remaining bytes of the frame are discarded, no header is written, and cur_page is unchanged.
- R10: The boundary check uses the boundary value held before any host write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| cfg_data | input | PG_W | Page value to write |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 3 | Error flags with final byte: [0] CRC, [1] alignment, [2] overrun |
| rx_match | input | 1 | Physical/multicast address match flag |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+8 | Packet memory byte address (page, offset) |
| mem_wdata | output | 8 | Packet memory write data |
| irq_rx | output | 1 | Intact frame stored pulse |
| irq_ovw | output | 1 | Ring full overwrite pulse |
| rx_missed | output | 1 | Frame discarded pulse |
| cur_page | output | PG_W | Current page register |
| bnd_page | output | PG_W | Boundary page register |

## Verification
Two events can fall in the same cycle: the host rewriting the boundary, and the write pointer crossing into a new page. The bench arranges a frame whose final byte is the first byte of the boundary page, and lowers the boundary in exactly that cycle. Under R10 the frame must still be dropped, with a missed pulse and cur_page unchanged. Making the same write one byte earlier must instead let the frame through, with a header and a wrapped next-page link.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HDR  = 2'd2,
        ST_DROP = 2'd3
    } rxr_state_e;

    localparam int HDR_BYTES = 4;
    localparam int OFF_W     = 8;
    localparam int LEN_W     = 16;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_STOP  = 2'd1;
    localparam logic [1:0] SEL_BND   = 2'd2;
    localparam logic [1:0] SEL_CUR   = 2'd3;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] page,
    input  logic [PG_W-1:0] ring_start,
    input  logic [PG_W-1:0] ring_stop,
    output logic [PG_W-1:0] page_nxt
);
    logic [PG_W:0] inc;

    always_comb begin
        inc      = {1'b0, page} + {{PG_W{1'b0}}, 1'b1};
        page_nxt = (inc >= {1'b0, ring_stop}) ? ring_start : inc[PG_W-1:0];
    end
endmodule

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
    import rxr_pkg::*;
#(
    parameter int          PG_W      = 8,
    parameter logic [PG_W-1:0] START_RST = 8'h40,
    parameter logic [PG_W-1:0] STOP_RST  = 8'h80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [PG_W-1:0] cfg_data,
    input  logic            cur_load,
    input  logic [PG_W-1:0] cur_val,
    output logic [PG_W-1:0] ring_start,
    output logic [PG_W-1:0] ring_stop,
    output logic [PG_W-1:0] bnd,
    output logic [PG_W-1:0] cur
);
    localparam logic [PG_W-1:0] BND_RST = STOP_RST - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_start <= START_RST;
            ring_stop  <= STOP_RST;
            bnd        <= BND_RST;
            cur        <= START_RST;
        end else begin
            if (cfg_we && cfg_sel == SEL_START) ring_start <= cfg_data;
            if (cfg_we && cfg_sel == SEL_STOP)  ring_stop  <= cfg_data;
            if (cfg_we && cfg_sel == SEL_BND)   bnd        <= cfg_data;
            // ring advance takes priority over a host write to the current page
            if (cur_load)                        cur        <= cur_val;
            else if (cfg_we && cfg_sel == SEL_CUR) cur     <= cfg_data;
        end
    end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rxr_pkg::*;
#(
    parameter int              PG_W      = 8,
    parameter logic [PG_W-1:0] START_RST = 8'h40,
    parameter logic [PG_W-1:0] STOP_RST  = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [PG_W-1:0]       cfg_data,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_last,
    input  logic [2:0]            rx_err,
    input  logic                  rx_match,
    output logic                  mem_we,
    output logic [PG_W+OFF_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic                  irq_rx,
    output logic                  irq_ovw,
    output logic                  rx_missed,
    output logic [PG_W-1:0]       cur_page,
    output logic [PG_W-1:0]       bnd_page
);
    localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

    rxr_state_e        state;
    logic [PG_W-1:0]   wpage;
    logic [OFF_W-1:0]  woff;
    logic [LEN_W-1:0]  len;
    logic [7:0]        stat;
    logic [PG_W-1:0]   nxt;
    logic [1:0]        hcnt;

    logic [PG_W-1:0]   ring_start, ring_stop, bnd, cur;
    logic [PG_W-1:0]   tgt_page, step_page;
    logic [OFF_W-1:0]  tgt_off;
    logic              new_pg, accept, ovf, wr_data, cur_load;
    logic [7:0]        hdr_byte;

    rxr_cfg_regs #(.PG_W(PG_W), .START_RST(START_RST), .STOP_RST(STOP_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .cur_load(cur_load), .cur_val(nxt),
        .ring_start(ring_start), .ring_stop(ring_stop), .bnd(bnd), .cur(cur)
    );

    rxr_page_step #(.PG_W(PG_W)) u_step (
        .page(tgt_page), .ring_start(ring_start), .ring_stop(ring_stop),
        .page_nxt(step_page)
    );

    // write target and boundary test
    always_comb begin
        tgt_page = (state == ST_IDLE) ? cur : wpage;
        tgt_off  = (state == ST_IDLE) ? DATA_OFF : woff;
        new_pg   = (state == ST_IDLE) || (woff == '0);
        accept   = rx_valid && (state == ST_IDLE || state == ST_DATA);
        ovf      = accept && new_pg && (tgt_page == bnd);
        wr_data  = accept && !ovf;
        unique case (hcnt)
            2'd0:    hdr_byte = stat;
            2'd1:    hdr_byte = 8'(nxt);
            2'd2:    hdr_byte = len[7:0];
            default: hdr_byte = len[15:8];
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wpage <= '0;
            woff  <= '0;
            len   <= '0;
            stat  <= '0;
            nxt   <= '0;
            hcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DATA: begin
                    if (ovf) begin
                        state <= rx_last ? ST_IDLE : ST_DROP;
                    end else if (accept) begin
                        len   <= (state == ST_IDLE) ? LEN_W'(1) : len + 1'b1;
                        woff  <= tgt_off + 1'b1;
                        wpage <= (tgt_off == OFF_LAST) ? step_page : tgt_page;
                        if (rx_last) begin
                            nxt   <= step_page;
                            stat  <= {2'b00, rx_match, 1'b0, rx_err[2], rx_err[1], rx_err[0], ~|rx_err};
                            hcnt  <= 2'd0;
                            state <= ST_HDR;
                        end else begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_HDR: begin
                    hcnt <= hcnt + 1'b1;
                    if (hcnt == 2'd3) state <= ST_IDLE;
                end
                ST_DROP: begin
                    if (rx_valid && rx_last) state <= ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        irq_rx    = 1'b0;
        cur_load  = 1'b0;
        unique case (state)
            ST_HDR: begin
                mem_we    = 1'b1;
                mem_addr  = {cur, {(OFF_W-2){1'b0}}, hcnt};
                mem_wdata = hdr_byte;
                cur_load  = (hcnt == 2'd3);
                irq_rx    = (hcnt == 2'd3) && stat[0];
            end
            ST_IDLE, ST_DATA: begin
                mem_we    = wr_data;
                mem_addr  = {tgt_page, tgt_off};
                mem_wdata = rx_data;
            end
            default: ;
        endcase
        irq_ovw   = ovf;
        rx_missed = ovf;
        cur_page  = cur;
        bnd_page  = bnd;
    end

    // R5: header bytes go to consecutive offsets
    p_hdr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && hcnt != 2'd3) |=>
            (state == ST_HDR && mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1));

    // R4: data writes stay inside the ring
    p_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && mem_we) |->
            (mem_addr[PG_W+OFF_W-1:OFF_W] >= ring_start && mem_addr[PG_W+OFF_W-1:OFF_W] < ring_stop));

    // R9: a dropped frame keeps the current page
    p_cur_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovw && !(cfg_we && cfg_sel == SEL_CUR)) |=> $stable(cur_page));

    // R9: no header follows a boundary hit
    p_ovw_no_hdr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovw |=> (state != ST_HDR));

    // R9: discarded bytes never reach memory
    p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> !mem_we);
endmodule

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
    localparam int PG_W = 8;
    localparam int RS = 2;
    localparam int RE = 6;
    localparam int RN = RE - RS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic rx_last = 1'b0;
    logic [2:0] rx_err = 3'd0;
    logic rx_match = 1'b0;
    logic mem_we, irq_rx, irq_ovw, rx_missed;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, cur_page, bnd_page;

    int checks = 0;
    int fails = 0;
    int n_rx = 0, n_ovw = 0, n_miss = 0, hdr_hits = 0, any_we = 0;
    int watch_pg = -1;
    bit done = 0;
    logic [7:0] bmem [0:65535];

    always #5 clk = ~clk;

    rx_ring_mgr #(.PG_W(PG_W), .START_RST(8'h40), .STOP_RST(8'h80)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_match(rx_match), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_rx(irq_rx), .irq_ovw(irq_ovw), .rx_missed(rx_missed),
        .cur_page(cur_page), .bnd_page(bnd_page)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            any_we <= any_we + 1;
            if (int'(mem_addr[15:8]) == watch_pg && mem_addr[7:0] < 8'd4) hdr_hits <= hdr_hits + 1;
        end
        if (irq_rx) n_rx <= n_rx + 1;
        if (irq_ovw) n_ovw <= n_ovw + 1;
        if (rx_missed) n_miss <= n_miss + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int n, input int err, input bit match, input int wr_idx,
                        input int wr_val, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(i * 7 + seed);
            rx_last  = (i == n - 1);
            rx_err   = (i == n - 1) ? 3'(err) : 3'd0;
            rx_match = match;
            cfg_we   = (i == wr_idx);
            cfg_sel  = 2'd2;
            cfg_data = 8'(wr_val);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; cfg_we = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    function automatic int pg_of(input int cur, input int p);
        return RS + ((cur - RS + p / 256) % RN);
    endfunction

    // store a frame that fits and check every byte, the header and the pointer
    task automatic good_frame(inout int cur_e, input int n, input int err, input bit match,
                              input int seed);
        int rx0, bad, badi, base, nxt_e, st_e;
        cfg(2'd2, (cur_e == RS) ? RE - 1 : cur_e - 1);
        rx0 = n_rx;
        send(n, err, match, -1, 0, seed);
        bad = 0; badi = 0;
        for (int i = 0; i < n; i++) begin
            int p = 4 + i;
            int a = pg_of(cur_e, p) * 256 + p % 256;
            if (bmem[a] !== 8'(i * 7 + seed) && bad == 0) begin bad = 1; badi = i; end
        end
        chk(bad == 0, "R3/R4 data placement", badi, -1);
        base  = cur_e * 256;
        nxt_e = RS + ((cur_e - RS + (4 + n - 1) / 256 + 1) % RN);
        st_e  = (match ? 32 : 0) | (err << 1) | (err == 0 ? 1 : 0);
        chk(bmem[base] == 8'(st_e), "R7 status byte", bmem[base], st_e);
        chk(bmem[base+1] == 8'(nxt_e), "R5/R4 next link", bmem[base+1], nxt_e);
        chk({bmem[base+3], bmem[base+2]} == 16'(n), "R6 length", {bmem[base+3], bmem[base+2]}, n);
        chk(cur_page == 8'(nxt_e), "R8 cur advance", cur_page, nxt_e);
        chk(n_rx - rx0 == (err == 0 ? 1 : 0), "R8 irq_rx", n_rx - rx0, err == 0);
        cur_e = nxt_e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cur_e, m0, o0, we0;
        repeat (3) @(negedge clk);
        chk(cur_page == 8'h40, "R1 cur reset", cur_page, 8'h40);
        chk(bnd_page == 8'h7f, "R1 bnd reset", bnd_page, 8'h7f);
        chk(mem_we == 1'b0 && any_we == 0, "R1 no write", any_we, 0);
        rst_n = 1'b1;
        cfg(2'd0, RS); cfg(2'd1, RE); cfg(2'd3, RS); cfg(2'd2, 3);
        chk(cur_page == 8'(RS), "R2 cur write", cur_page, RS);
        chk(bnd_page == 8'd3, "R2 bnd write", bnd_page, 3);
        cur_e = RS;

        // sweep of lengths, error flags and match
        for (int k = 0; k < 27; k++) good_frame(cur_e, 1 + 29 * k, k % 8, k[0], k);
        good_frame(cur_e, 252, 0, 1'b0, 40);
        good_frame(cur_e, 253, 0, 1'b1, 41);
        good_frame(cur_e, 508, 3, 1'b0, 42);
        good_frame(cur_e, 764, 0, 1'b0, 43);

        // R9: crossing into the boundary page drops the frame
        cfg(2'd3, RS); cfg(2'd2, 5); cur_e = RS;
        watch_pg = RS; hdr_hits = 0;
        m0 = n_miss; o0 = n_ovw;
        send(765, 0, 1'b0, -1, 0, 50);
        chk(n_miss - m0 == 1, "R9 missed pulse", n_miss - m0, 1);
        chk(n_ovw - o0 == 1, "R9 ovw pulse", n_ovw - o0, 1);
        chk(hdr_hits == 0, "R9 no header", hdr_hits, 0);
        chk(cur_page == 8'(RS), "R9 cur kept", cur_page, RS);

        // fill up to boundary exactly, then first byte hits boundary
        send(764, 0, 1'b0, -1, 0, 51);
        chk(cur_page == 8'd5, "R8 fill to boundary", cur_page, 5);
        m0 = n_miss; we0 = any_we;
        send(10, 0, 1'b0, -1, 0, 52);
        chk(n_miss - m0 == 1, "R9 first page hit", n_miss - m0, 1);
        chk(any_we == we0, "R9 no bytes written", any_we - we0, 0);
        chk(cur_page == 8'd5, "R9 cur kept first", cur_page, 5);
        cur_e = 5;
        good_frame(cur_e, 10, 0, 1'b1, 53);
        chk(cur_e == RS, "R4 link wraps", cur_e, RS);

        // R10: boundary write in the crossing cycle is not seen
        cfg(2'd3, RS); cfg(2'd2, 5);
        m0 = n_miss;
        send(765, 0, 1'b0, 764, 1, 60);
        chk(n_miss - m0 == 1, "R10 same-cycle bnd write", n_miss - m0, 1);
        chk(cur_page == 8'(RS), "R10 cur kept", cur_page, RS);
        cfg(2'd2, 5);
        m0 = n_miss;
        send(765, 0, 1'b0, 763, 1, 61);
        chk(n_miss - m0 == 0, "R10 earlier bnd write", n_miss - m0, 0);
        chk(cur_page == 8'(RS), "R10 wrapped cur", cur_page, RS);
        chk(bmem[RS*256+1] == 8'(RS), "R10 link", bmem[RS*256+1], RS);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule